// File: doc/BRIEF.md
# Request-Grant Protocol Rule Monitor

This block is a synthesizable runtime checker. It sits beside a request/acknowledge/grant handshake and a pair of processor write-ownership indicators. Every clock it evaluates a fixed set of temporal rules and raises a sticky error flag for each rule that breaks. It only observes its inputs and never drives the protocol. Flags can be read in silicon, sent to a debug register, or watched by a simulation bench.

Each rule is a small state machine. The invariant rule has an absorbing error state. The fixed-latency rule uses a shift register of pending requests, so overlapping requests each carry their own deadline. The "acknowledge until grant" rule tracks one open obligation, and an end-of-test strobe turns any obligation still open into a liveness failure. A separate eventuality tracker reports requests that were never followed by a grant. A combined flag and a count of open obligations summarise the state.

Top module: `hs_rule_monitor`

## Requirements
- R1: If `wr_a_i` and `wr_b_i` are both high in a cycle, `err_mutex_o` is high from the next cycle on.
- R2: Every error output (`err_mutex_o`, `err_latency_o`, `err_until_o`, `err_live_o`, `err_eventual_o`, `err_any_o`) stays high once set, whatever later inputs do, until a synchronous reset.
- R3: A cycle t with `req_i` high requires `grant_i` high in cycle t+LAT (LAT defaults to 3). If it is missing, `err_latency_o` rises in cycle t+LAT+1. Requests in consecutive cycles are each checked against their own deadline.
- R4: A cycle t with `req_i` high requires `ack_i` high in every cycle from t+1 up to, but not including, the first cycle after t in which `grant_i` is high. A cycle in that span with both `ack_i` and `grant_i` low sets `err_until_o` in the following cycle and ends the obligation. A grant in cycle t+1 discharges the obligation with no acknowledge required.
- R5: If `eot_i` is high in a cycle while an R4 obligation is open and `grant_i` is low, `err_live_o` is high from the next cycle on.
- R6: If `eot_i` is high in a cycle while some earlier request has not yet been followed by a grant in a later cycle, and `grant_i` is low in that cycle, `err_eventual_o` is high from the next cycle on. This holds even when the R4 obligation was already ended by a violation.
- R7: `err_any_o` is high exactly when at least one individual error flag is high. It rises in the same cycle as the first flag, one cycle after the violating cycle.
- R8: `pending_o` equals the number of requests seen in the previous LAT cycles, plus 1 if an R4 obligation is open, plus 1 if any request is still awaiting a grant.
- R9: A synchronous active-high `rst_i` clears all flags, the pending count and every obligation. The first cycle after reset shows all outputs at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Observed request |
| ack_i | input | 1 | Observed acknowledge |
| grant_i | input | 1 | Observed grant |
| wr_a_i | input | 1 | Processor A holds the line in write mode |
| wr_b_i | input | 1 | Processor B holds the line in write mode |
| eot_i | input | 1 | End-of-test strobe; open obligations become failures |
| err_mutex_o | output | 1 | Write-ownership exclusion broken |
| err_latency_o | output | 1 | Grant missing at its fixed deadline |
| err_until_o | output | 1 | Acknowledge dropped before grant |
| err_live_o | output | 1 | Acknowledge-until-grant obligation open at end of test |
| err_eventual_o | output | 1 | Request never granted by end of test |
| err_any_o | output | 1 | Registered OR of all flags |
| pending_o | output | $clog2(LAT+3) | Count of open obligations |

## Verification
The bound checker tests these rules on every cycle: the exclusion trip, the fixed-latency deadline (using its own request history), an acknowledge drop in the cycle right after a request, and end-of-test failures right after a request. It also checks flag stickiness, agreement between the combined flag and the individual flags, the bound on the pending count, and cleanliness after reset. Some behaviours need whole scenarios and the bench's reference model to show. These are: overlapping requests each keeping their own deadline, an early grant that removes the need for acknowledge, late grants that satisfy the eventuality rule but not the latency rule, and an eventuality failure after the until obligation has already been abandoned.

// File: rtl/hs_rule_pkg.sv
package hs_rule_pkg;

  typedef enum logic {
    INV_START = 1'b0,
    INV_ERROR = 1'b1
  } inv_state_e;

  typedef enum logic {
    UN_IDLE = 1'b0,
    UN_OPEN = 1'b1
  } until_state_e;

  typedef enum logic {
    EV_CLEAR = 1'b0,
    EV_WAIT  = 1'b1
  } ev_state_e;

  typedef struct packed {
    logic mutex;
    logic latency;
    logic until_drop;
    logic until_live;
    logic eventual;
  } rule_flags_t;

  // Number of set bits in a vector of up to 32 bits.
  function automatic logic [7:0] count_set(input logic [31:0] v);
    logic [7:0] n;
    n = 8'd0;
    for (int i = 0; i < 32; i++) begin
      n = n + {7'd0, v[i]};
    end
    return n;
  endfunction

  function automatic logic any_flag(input rule_flags_t f);
    return |f;
  endfunction

endpackage

// File: rtl/hs_inv_watch.sv
module hs_inv_watch
  import hs_rule_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic hold_i,
  output logic trip_o,
  output logic err_o
);

  inv_state_e state_q;

  // A trip is the first cycle in which the invariant fails.
  assign trip_o = (state_q == INV_START) && !hold_i;
  assign err_o  = (state_q == INV_ERROR);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= INV_START;
    end else if (trip_o) begin
      state_q <= INV_ERROR;
    end
  end

endmodule

// File: rtl/hs_lat_watch.sv
module hs_lat_watch #(
  parameter int LAT = 3
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic           req_i,
  input  logic           grant_i,
  output logic [LAT-1:0] pipe_o,
  output logic           miss_o,
  output logic           err_o
);

  logic [LAT-1:0] pipe_q;
  logic           err_q;
  logic           due;

  // pipe_q[k] holds the request from k+1 cycles ago.
  generate
    if (LAT == 1) begin : g_single
      always_ff @(posedge clk_i) begin
        if (rst_i) pipe_q <= '0;
        else       pipe_q <= req_i;
      end
    end else begin : g_shift
      always_ff @(posedge clk_i) begin
        if (rst_i) pipe_q <= '0;
        else       pipe_q <= {pipe_q[LAT-2:0], req_i};
      end
    end
  endgenerate

  assign due    = pipe_q[LAT-1];
  assign miss_o = due && !grant_i;

  always_ff @(posedge clk_i) begin
    if (rst_i)       err_q <= 1'b0;
    else if (miss_o) err_q <= 1'b1;
  end

  assign pipe_o = pipe_q;
  assign err_o  = err_q;

endmodule

// File: rtl/hs_until_watch.sv
module hs_until_watch
  import hs_rule_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic req_i,
  input  logic ack_i,
  input  logic grant_i,
  input  logic eot_i,
  output logic open_o,
  output logic drop_o,
  output logic live_o,
  output logic err_drop_o,
  output logic err_live_o
);

  until_state_e state_q;
  until_state_e state_d;
  logic         err_drop_q;
  logic         err_live_q;

  assign open_o = (state_q == UN_OPEN);
  // An open obligation fails when neither ack nor the discharging grant shows.
  assign drop_o = open_o && !grant_i && !ack_i;
  assign live_o = open_o && eot_i && !grant_i;

  always_comb begin
    state_d = state_q;
    if (req_i) begin
      state_d = UN_OPEN;
    end else if (open_o && (grant_i || !ack_i)) begin
      state_d = UN_IDLE;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q    <= UN_IDLE;
      err_drop_q <= 1'b0;
      err_live_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (drop_o) err_drop_q <= 1'b1;
      if (live_o) err_live_q <= 1'b1;
    end
  end

  assign err_drop_o = err_drop_q;
  assign err_live_o = err_live_q;

endmodule

// File: rtl/hs_eventual_watch.sv
module hs_eventual_watch
  import hs_rule_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic req_i,
  input  logic grant_i,
  input  logic eot_i,
  output logic wait_o,
  output logic trip_o,
  output logic err_o
);

  ev_state_e state_q;
  ev_state_e state_d;
  logic      err_q;

  assign wait_o = (state_q == EV_WAIT);
  assign trip_o = wait_o && eot_i && !grant_i;

  always_comb begin
    state_d = state_q;
    if (req_i)        state_d = EV_WAIT;
    else if (grant_i) state_d = EV_CLEAR;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= EV_CLEAR;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (trip_o) err_q <= 1'b1;
    end
  end

  assign err_o = err_q;

endmodule

// File: rtl/hs_rule_monitor.sv
module hs_rule_monitor
  import hs_rule_pkg::*;
#(
  parameter  int LAT    = 3,
  localparam int PEND_W = $clog2(LAT + 3)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              req_i,
  input  logic              ack_i,
  input  logic              grant_i,
  input  logic              wr_a_i,
  input  logic              wr_b_i,
  input  logic              eot_i,
  output logic              err_mutex_o,
  output logic              err_latency_o,
  output logic              err_until_o,
  output logic              err_live_o,
  output logic              err_eventual_o,
  output logic              err_any_o,
  output logic [PEND_W-1:0] pending_o
);

  // Named internal events.
  logic           mutex_trip;
  logic           lat_miss;
  logic           until_drop;
  logic           until_live;
  logic           ev_trip;
  logic [LAT-1:0] lat_pipe;
  logic           until_open;
  logic           ev_wait;
  rule_flags_t    trips;
  logic           err_any_q;

  hs_inv_watch u_mutex (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .hold_i (!(wr_a_i && wr_b_i)),
    .trip_o (mutex_trip),
    .err_o  (err_mutex_o)
  );

  hs_lat_watch #(.LAT(LAT)) u_lat (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .req_i   (req_i),
    .grant_i (grant_i),
    .pipe_o  (lat_pipe),
    .miss_o  (lat_miss),
    .err_o   (err_latency_o)
  );

  hs_until_watch u_until (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .req_i      (req_i),
    .ack_i      (ack_i),
    .grant_i    (grant_i),
    .eot_i      (eot_i),
    .open_o     (until_open),
    .drop_o     (until_drop),
    .live_o     (until_live),
    .err_drop_o (err_until_o),
    .err_live_o (err_live_o)
  );

  hs_eventual_watch u_ev (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .req_i   (req_i),
    .grant_i (grant_i),
    .eot_i   (eot_i),
    .wait_o  (ev_wait),
    .trip_o  (ev_trip),
    .err_o   (err_eventual_o)
  );

  always_comb begin
    trips.mutex      = mutex_trip;
    trips.latency    = lat_miss;
    trips.until_drop = until_drop;
    trips.until_live = until_live;
    trips.eventual   = ev_trip;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)               err_any_q <= 1'b0;
    else if (any_flag(trips)) err_any_q <= 1'b1;
  end

  assign err_any_o = err_any_q;

  assign pending_o = PEND_W'(count_set(32'(lat_pipe))
                             + {7'd0, until_open}
                             + {7'd0, ev_wait});

endmodule

// File: rtl/hs_rule_checker.sv
module hs_rule_checker #(
  parameter int LAT    = 3,
  parameter int PEND_W = 3
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              req_i,
  input logic              ack_i,
  input logic              grant_i,
  input logic              wr_a_i,
  input logic              wr_b_i,
  input logic              eot_i,
  input logic              err_mutex_o,
  input logic              err_latency_o,
  input logic              err_until_o,
  input logic              err_live_o,
  input logic              err_eventual_o,
  input logic              err_any_o,
  input logic [PEND_W-1:0] pending_o
);

  // Independent request history, kept by the checker itself.
  logic [LAT-1:0] hist_q;
  logic [4:0]     flags;

  generate
    if (LAT == 1) begin : g_h1
      always_ff @(posedge clk_i) begin
        if (rst_i) hist_q <= '0;
        else       hist_q <= req_i;
      end
    end else begin : g_hn
      always_ff @(posedge clk_i) begin
        if (rst_i) hist_q <= '0;
        else       hist_q <= {hist_q[LAT-2:0], req_i};
      end
    end
  endgenerate

  assign flags = {err_mutex_o, err_latency_o, err_until_o, err_live_o, err_eventual_o};

  assert_mutex_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_a_i && wr_b_i) |=> err_mutex_o);

  assert_sticky_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (|{flags, err_any_o}) |=> (({flags, err_any_o} & $past({flags, err_any_o})) == $past({flags, err_any_o})));

  assert_latency_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (hist_q[LAT-1] && !grant_i) |=> err_latency_o);

  assert_until_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (req_i ##1 (!grant_i && !ack_i)) |=> err_until_o);

  assert_live_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(req_i) && !$past(rst_i) && eot_i && !grant_i) |=> err_live_o);

  assert_eventual_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(req_i) && !$past(rst_i) && eot_i && !grant_i) |=> err_eventual_o);

  assert_any_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    err_any_o == (|flags));

  assert_pending_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    32'(pending_o) <= LAT + 2);

  assert_reset_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (pending_o == '0 && !err_any_o && flags == 5'd0));

endmodule

bind hs_rule_monitor hs_rule_checker #(.LAT(LAT), .PEND_W(PEND_W)) u_rule_chk (
  .clk_i          (clk_i),
  .rst_i          (rst_i),
  .req_i          (req_i),
  .ack_i          (ack_i),
  .grant_i        (grant_i),
  .wr_a_i         (wr_a_i),
  .wr_b_i         (wr_b_i),
  .eot_i          (eot_i),
  .err_mutex_o    (err_mutex_o),
  .err_latency_o  (err_latency_o),
  .err_until_o    (err_until_o),
  .err_live_o     (err_live_o),
  .err_eventual_o (err_eventual_o),
  .err_any_o      (err_any_o),
  .pending_o      (pending_o)
);

// File: tb/tb_hs_rule_monitor.sv
module tb_hs_rule_monitor;

  localparam int LAT    = 3;
  localparam int PEND_W = $clog2(LAT + 3);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, ack = 1'b0, grant = 1'b0, wa = 1'b0, wb = 1'b0, eot = 1'b0;
  logic e_mx, e_lat, e_un, e_lv, e_ev, e_any;
  logic [PEND_W-1:0] pend;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  hs_rule_monitor #(.LAT(LAT)) dut (
    .clk_i(clk), .rst_i(rst), .req_i(req), .ack_i(ack), .grant_i(grant),
    .wr_a_i(wa), .wr_b_i(wb), .eot_i(eot),
    .err_mutex_o(e_mx), .err_latency_o(e_lat), .err_until_o(e_un),
    .err_live_o(e_lv), .err_eventual_o(e_ev), .err_any_o(e_any),
    .pending_o(pend)
  );

  // Behavioural reference: deadlines and waiting requests held in queues.
  int cyc = 0;
  int deadlines[$];
  int waiting[$];
  bit m_open = 0;
  bit m_mx = 0, m_lat = 0, m_un = 0, m_lv = 0, m_ev = 0, m_any = 0;
  bit started = 0;

  always @(posedge clk) begin : model
    bit t_mx, t_lat, t_un, t_lv, t_ev;
    started = 1;
    if (rst) begin
      deadlines.delete();
      waiting.delete();
      m_open = 0;
      {m_mx, m_lat, m_un, m_lv, m_ev, m_any} = '0;
    end else begin
      t_mx  = wa && wb;
      t_lat = 0;
      if (deadlines.size() > 0 && deadlines[0] == cyc) begin
        void'(deadlines.pop_front());
        t_lat = !grant;
      end
      if (req) deadlines.push_back(cyc + LAT);
      t_un = m_open && !ack && !grant;
      t_lv = m_open && eot && !grant;
      if (req) m_open = 1;
      else if (grant || !ack) m_open = 0;
      t_ev = (waiting.size() > 0) && eot && !grant;
      if (grant) waiting.delete();
      if (req) waiting.push_back(cyc);
      m_mx  = m_mx  | t_mx;
      m_lat = m_lat | t_lat;
      m_un  = m_un  | t_un;
      m_lv  = m_lv  | t_lv;
      m_ev  = m_ev  | t_ev;
      m_any = m_any | t_mx | t_lat | t_un | t_lv | t_ev;
    end
    cyc++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  // Compare every output against the model on every cycle.
  always @(negedge clk) begin
    if (started) begin
      chk("R1 err_mutex", int'(e_mx), int'(m_mx));
      chk("R3 err_latency", int'(e_lat), int'(m_lat));
      chk("R4 err_until", int'(e_un), int'(m_un));
      chk("R5 err_live", int'(e_lv), int'(m_lv));
      chk("R6 err_eventual", int'(e_ev), int'(m_ev));
      chk("R7 err_any", int'(e_any), int'(m_any));
      chk("R8 pending", int'(pend), deadlines.size() + int'(m_open) + int'(waiting.size() > 0));
    end
  end

  task automatic step(input bit r, input bit a, input bit g, input bit x, input bit y, input bit e);
    @(negedge clk);
    req = r; ack = a; grant = g; wa = x; wb = y; eot = e;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    {req, ack, grant, wa, wb, eot} = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    do_reset();
    chk("R9 reset any", int'(e_any), 0);
    chk("R9 reset pending", int'(pend), 0);

    // Clean handshake
    step(1, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0);
    chk("R8 pending after one req", int'(pend), 3);
    step(0, 1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1);
    idle();
    chk("R3 clean no error", int'(e_any), 0);
    chk("R8 pending drained", int'(pend), 0);

    // Back-to-back requests, second deadline missed
    do_reset();
    step(1, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0);
    step(0, 1, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    chk("R3 first deadline met", int'(e_lat), 0);
    idle();
    chk("R3 second deadline missed", int'(e_lat), 1);
    chk("R4 until held", int'(e_un), 0);
    chk("R7 any follows latency", int'(e_any), 1);

    // Mutual exclusion
    do_reset();
    step(0, 0, 0, 1, 1, 0);
    idle();
    chk("R1 mutex flagged", int'(e_mx), 1);
    chk("R7 any same cycle", int'(e_any), 1);
    idle(); idle(); idle();
    chk("R2 mutex sticky", int'(e_mx), 1);
    do_reset();
    chk("R9 mutex cleared", int'(e_mx), 0);
    chk("R9 any cleared", int'(e_any), 0);

    // Ack drop
    do_reset();
    step(1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    idle();
    chk("R4 ack drop flagged", int'(e_un), 1);

    // Grant right after request discharges without ack
    do_reset();
    step(1, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0);
    idle();
    chk("R4 early grant no error", int'(e_un), 0);

    // Obligation open at end of test
    do_reset();
    step(1, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 1);
    idle();
    chk("R5 open at eot", int'(e_lv), 1);
    chk("R6 ungranted at eot", int'(e_ev), 1);

    // Eventuality fails after until already abandoned
    do_reset();
    step(1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1);
    idle();
    chk("R6 eventual without live", int'(e_ev), 1);
    chk("R5 no live after drop", int'(e_lv), 0);

    // Late grant satisfies eventuality
    do_reset();
    step(1, 0, 0, 0, 0, 0);
    idle(); idle(); idle(); idle();
    step(0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1);
    idle();
    chk("R6 late grant ok", int'(e_ev), 0);

    // Random traffic with occasional resets
    do_reset();
    for (int i = 0; i < 600; i++) begin
      if (($urandom % 97) == 0) do_reset();
      step(1'(($urandom % 4) == 0), 1'(($urandom % 5) != 0), 1'(($urandom % 3) == 0),
           1'(($urandom % 6) == 0), 1'(($urandom % 6) == 0), 1'(($urandom % 40) == 0));
    end
    idle(); idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule